// File: doc/BRIEF.md
# Outstanding Doorbell Message Tracker

This block keeps account of doorbell messages sent to a remote endpoint that have not yet been answered. A memory-mapped write port takes a 16-bit info payload. The destination ID comes from a programmable transmit-doorbell setting and is captured when the write is accepted. Each accepted write is issued at once on an outbound request handshake with a 4-bit tag. The tag is allocated in sequence from a 16-slot ring.

Responses come back on an inbound port that carries a tag and an ok/error flag. Finished messages leave the ring oldest first and go into a small completion queue. The user pops each message from that queue together with its final status: done, error or timeout. The oldest outstanding entry is watched by a response timer. If that timer reaches the programmed limit, the entry is retired with a timeout status. A status output reports how many messages are outstanding and how many responses were dropped.

Top module: `dbell_track`

## Requirements
- R1: After reset, stat_count is 0, stat_drops is 0, cq_valid is low, and sub_wait is low while req_ready is high.
- R2: A write accepted while sub_wait is low drives req_valid. On req_tag it carries the next tag of a sequence that starts at 0 and wraps modulo 16. It also carries cfg_dest_id on req_dest and sub_info on req_info, and stat_count rises by one.
- R3: While 16 messages are outstanding, sub_wait stays high and req_valid stays low. Once the count falls below 16, sub_wait is low again.
- R4: A response with rsp_err low whose tag matches a pending entry completes that entry with status code 1 (done). The completion carries the entry's tag, destination ID and info.
- R5: A response with rsp_err high on a pending tag completes that entry with status code 2 (error).
- R6: A response whose tag is not pending is dropped. It increments stat_drops, leaves stat_count unchanged and produces no completion.
- R7: An oldest entry that stays unanswered is retired with status code 3 (timeout) on the (cfg_timeout+1)-th clock edge after it became the oldest entry. It stays counted as outstanding before that edge.
- R8: Completions leave in allocation order. An answered entry waits behind an older entry that is still pending, and it stays in stat_count while it waits.
- R9: While the completion queue (4 entries) is full and not being read, nothing retires, and stat_count does not fall until the user pops a completion with cq_read.
- R10: While req_ready is low, sub_wait is high and no message is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dest_id | input | 8 | Programmed destination ID for new doorbells |
| cfg_timeout | input | 16 | Response timeout limit in clock cycles |
| sub_write | input | 1 | Doorbell write request |
| sub_info | input | 16 | Doorbell info payload |
| sub_wait | output | 1 | Waitrequest; the write is held while high |
| req_valid | output | 1 | Outbound doorbell request valid |
| req_ready | input | 1 | Outbound side accepts the request |
| req_tag | output | 4 | Tag of the outbound doorbell |
| req_dest | output | 8 | Destination ID of the outbound doorbell |
| req_info | output | 16 | Info payload of the outbound doorbell |
| rsp_valid | input | 1 | Response arrives |
| rsp_tag | input | 4 | Tag of the response |
| rsp_err | input | 1 | Response reports an error |
| cq_valid | output | 1 | Completion queue holds an entry |
| cq_read | input | 1 | Pop the head completion |
| cq_status | output | 2 | 1 done, 2 error, 3 timeout |
| cq_tag | output | 4 | Tag of the completed message |
| cq_dest | output | 8 | Destination ID of the completed message |
| cq_info | output | 16 | Info payload of the completed message |
| stat_count | output | 5 | Number of outstanding messages |
| stat_drops | output | 8 | Count of dropped responses |

## Verification
The tracker is tested with several response patterns. Responses in allocation order exercise the plain done path. Responses out of order, including an error answer for a younger entry, show that retirement keeps allocation order and that the error status is kept. Responses with stale or unused tags must move only the drop count. A fill to sixteen entries separates the waitrequest hold from normal flow, and a response burst with the queue left unread separates the retirement stall from lost completions. With a short timeout, a lone silent message and then a silent message ahead of an answered one show the exact timeout edge and that a timeout does not reorder the queue.

// File: rtl/dbell_track.sv
module dbell_track #(
  parameter int DEPTH    = 16,
  parameter int INFO_W   = 16,
  parameter int DEST_W   = 8,
  parameter int TO_W     = 16,
  parameter int CQ_DEPTH = 4,
  parameter int DROP_W   = 8,
  localparam int TAG_W   = $clog2(DEPTH),
  localparam int CNT_W   = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEST_W-1:0] cfg_dest_id,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic              sub_write,
  input  logic [INFO_W-1:0] sub_info,
  output logic              sub_wait,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [TAG_W-1:0]  req_tag,
  output logic [DEST_W-1:0] req_dest,
  output logic [INFO_W-1:0] req_info,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic              rsp_err,
  output logic              cq_valid,
  input  logic              cq_read,
  output logic [1:0]        cq_status,
  output logic [TAG_W-1:0]  cq_tag,
  output logic [DEST_W-1:0] cq_dest,
  output logic [INFO_W-1:0] cq_info,
  output logic [CNT_W-1:0]  stat_count,
  output logic [DROP_W-1:0] stat_drops
);
  localparam int CQ_AW = $clog2(CQ_DEPTH);
  localparam int ENT_W = 2 + TAG_W + DEST_W + INFO_W;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CQ_AW:0]   CQ_FULL  = (CQ_AW+1)'(CQ_DEPTH);
  localparam logic [1:0] S_FREE = 2'd0, S_PEND = 2'd1, S_OK = 2'd2, S_ERR = 2'd3;
  localparam logic [1:0] ST_DONE = 2'd1, ST_ERR = 2'd2, ST_TMO = 2'd3;

  logic [1:0]        slot_st   [DEPTH];
  logic [INFO_W-1:0] slot_info [DEPTH];
  logic [DEST_W-1:0] slot_dest [DEPTH];
  logic [TAG_W:0]    wr_ptr, rd_ptr;
  logic [TO_W-1:0]   timer;
  logic [ENT_W-1:0]  cq_mem [CQ_DEPTH];
  logic [CQ_AW:0]    cq_wp, cq_rp;
  logic [DROP_W-1:0] drops;

  logic [CNT_W-1:0] count;
  logic [TAG_W-1:0] head, wslot;
  logic [1:0]       head_st, ret_status;
  logic full, fire, head_pend, expired, cq_full, retire, rsp_hit, pop;

  assign count      = wr_ptr - rd_ptr;
  assign head       = rd_ptr[TAG_W-1:0];
  assign wslot      = wr_ptr[TAG_W-1:0];
  assign full       = count == FULL_CNT;
  assign req_valid  = sub_write && !full;
  assign sub_wait   = full || !req_ready;
  assign fire       = req_valid && req_ready;
  assign req_tag    = wslot;
  assign req_dest   = cfg_dest_id;
  assign req_info   = sub_info;

  assign head_st    = slot_st[head];
  assign head_pend  = head_st == S_PEND;
  assign expired    = head_pend && timer >= cfg_timeout;
  assign cq_full    = (cq_wp - cq_rp) == CQ_FULL;
  assign retire     = !cq_full && (expired || head_st == S_OK || head_st == S_ERR);
  assign ret_status = expired ? ST_TMO : (head_st == S_OK ? ST_DONE : ST_ERR);
  assign rsp_hit    = rsp_valid && slot_st[rsp_tag] == S_PEND && !(retire && rsp_tag == head);

  assign cq_valid   = cq_wp != cq_rp;
  assign pop        = cq_read && cq_valid;
  assign {cq_status, cq_tag, cq_dest, cq_info} = cq_mem[cq_rp[CQ_AW-1:0]];
  assign stat_count = count;
  assign stat_drops = drops;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_st[i] <= S_FREE;
      wr_ptr <= '0;
      rd_ptr <= '0;
      timer  <= '0;
      drops  <= '0;
      cq_wp  <= '0;
      cq_rp  <= '0;
    end else begin
      if (fire) begin
        slot_st[wslot] <= S_PEND;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (rsp_hit) slot_st[rsp_tag] <= rsp_err ? S_ERR : S_OK;
      if (rsp_valid && !rsp_hit) drops <= drops + 1'b1;
      if (retire) begin
        slot_st[head] <= S_FREE;
        rd_ptr <= rd_ptr + 1'b1;
        cq_wp  <= cq_wp + 1'b1;
      end
      if (pop) cq_rp <= cq_rp + 1'b1;
      if (retire || count == '0) timer <= '0;
      else if (head_pend && timer < cfg_timeout) timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      slot_info[wslot] <= sub_info;
      slot_dest[wslot] <= cfg_dest_id;
    end
    if (retire)
      cq_mem[cq_wp[CQ_AW-1:0]] <= {ret_status, head, slot_dest[head], slot_info[head]};
  end
endmodule

// File: rtl/dbell_track_chk.sv
module dbell_track_chk #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sub_wait,
  input logic              req_valid,
  input logic              req_ready,
  input logic              retire,
  input logic              cq_full,
  input logic              cq_read,
  input logic              cq_valid,
  input logic [1:0]        cq_status,
  input logic              rsp_valid,
  input logic [CNT_W-1:0]  count,
  input logic [DROP_W-1:0] drops
);
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count == CNT_W'(DEPTH) |-> sub_wait && !req_valid);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R2
  alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !retire |=> count == $past(count) + 1'b1);
  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cq_full && !cq_read |=> count >= $past(count));
  // R6
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(drops));
  // R10
  ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> sub_wait);
  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cq_valid |-> cq_status != 2'd0);
endmodule

bind dbell_track dbell_track_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_wait(sub_wait), .req_valid(req_valid),
  .req_ready(req_ready), .retire(retire), .cq_full(cq_full), .cq_read(cq_read),
  .cq_valid(cq_valid), .cq_status(cq_status), .rsp_valid(rsp_valid),
  .count(count), .drops(drops)
);

// File: tb/dbell_track_test.sv
`timescale 1ns/1ps
module dbell_track_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0]  cfg_dest_id = 8'h20;
  logic [15:0] cfg_timeout = 16'd1000;
  logic sub_write = 0;
  logic [15:0] sub_info = 0;
  logic sub_wait, req_valid;
  logic req_ready = 1;
  logic [3:0] req_tag;
  logic [7:0] req_dest;
  logic [15:0] req_info;
  logic rsp_valid = 0;
  logic [3:0] rsp_tag = 0;
  logic rsp_err = 0;
  logic cq_valid;
  logic cq_read = 0;
  logic [1:0] cq_status;
  logic [3:0] cq_tag;
  logic [7:0] cq_dest;
  logic [15:0] cq_info;
  logic [4:0] stat_count;
  logic [7:0] stat_drops;

  always #4 clk = ~clk;

  dbell_track uut (.*);

  int nchk = 0, nerr = 0;
  logic [29:0] exp_q[$];
  logic [15:0] tag_info [16];
  logic [7:0]  tag_dest [16];
  int nxt_tag = 0;
  logic drain_en = 1;

  task automatic check_eq(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic submit(input logic [15:0] info);
    @(negedge clk);
    sub_write = 1;
    sub_info = info;
    while (sub_wait) @(negedge clk);
    check_eq("R2 req_tag", req_tag, nxt_tag);
    check_eq("R2 req_info", req_info, info);
    tag_info[nxt_tag] = info;
    tag_dest[nxt_tag] = cfg_dest_id;
    nxt_tag = (nxt_tag + 1) % 16;
    @(negedge clk);
    sub_write = 0;
  endtask

  task automatic respond(input int tag, input logic err);
    @(negedge clk);
    rsp_valid = 1;
    rsp_tag = 4'(tag);
    rsp_err = err;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic expect_c(input logic [1:0] st, input int tag);
    exp_q.push_back({st, 4'(tag), tag_dest[tag], tag_info[tag]});
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !cq_valid) break;
    end
    check_eq("R4 all completions delivered", exp_q.size(), 0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      cq_read = 0;
      if (drain_en && cq_valid) begin
        nchk++;
        if (exp_q.size() == 0) begin
          nerr++;
          $display("FAIL R6 unexpected completion actual=%0h expected=none",
                   {cq_status, cq_tag, cq_dest, cq_info});
        end else begin
          logic [29:0] e;
          e = exp_q.pop_front();
          if ({cq_status, cq_tag, cq_dest, cq_info} != e) begin
            nerr++;
            $display("FAIL R4/R5/R7/R8 completion actual=%0h expected=%0h",
                     {cq_status, cq_tag, cq_dest, cq_info}, e);
          end
        end
        cq_read = 1;
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check_eq("R1 count", stat_count, 0);
    check_eq("R1 drops", stat_drops, 0);
    check_eq("R1 cq_valid", cq_valid, 0);
    check_eq("R1 sub_wait", sub_wait, 0);

    // R2 R4 R5 R8: out-of-order answers, error on youngest
    cfg_dest_id = 8'h21; submit(16'hA000);
    cfg_dest_id = 8'h22; submit(16'hA001);
    cfg_dest_id = 8'h23; submit(16'hA002);
    check_eq("R2 count after three", stat_count, 3);
    expect_c(2'd1, 0);
    respond(0, 0);
    expect_c(2'd1, 1);
    expect_c(2'd2, 2);
    respond(2, 1);
    repeat (5) @(negedge clk);
    check_eq("R8 answered entry held behind pending", stat_count, 2);
    check_eq("R8 no early completion", exp_q.size(), 2);
    respond(1, 0);
    wait_drain();
    check_eq("R4 count after answers", stat_count, 0);

    // R6: unused and stale tags
    respond(5, 0);
    respond(0, 0);
    repeat (3) @(negedge clk);
    check_eq("R6 drops", stat_drops, 2);
    check_eq("R6 count unchanged", stat_count, 0);
    check_eq("R6 no completion", cq_valid, 0);

    // R3: fill all sixteen
    cfg_dest_id = 8'h30;
    for (int i = 0; i < 16; i++) submit(16'hB000 + 16'(i));
    check_eq("R3 count full", stat_count, 16);
    @(negedge clk);
    sub_write = 1;
    sub_info = 16'hBEEF;
    #1;
    check_eq("R3 sub_wait when full", sub_wait, 1);
    check_eq("R3 req_valid when full", req_valid, 0);
    repeat (3) @(negedge clk);
    check_eq("R3 count stays full", stat_count, 16);
    sub_write = 0;
    expect_c(2'd1, 3);
    respond(3, 0);
    repeat (3) @(negedge clk);
    check_eq("R3 count below full", stat_count, 15);
    check_eq("R3 sub_wait released", sub_wait, 0);
    submit(16'hB100);
    for (int i = 0; i < 16; i++) begin
      int t;
      t = (4 + i) % 16;
      expect_c(2'd1, t);
      respond(t, 0);
    end
    wait_drain();
    check_eq("R3 count after drain", stat_count, 0);

    // R9: completion queue left full
    drain_en = 0;
    for (int i = 0; i < 6; i++) submit(16'hC000 + 16'(i));
    for (int i = 0; i < 6; i++) begin
      int t;
      t = (4 + i) % 16;
      expect_c(2'd1, t);
      respond(t, 0);
    end
    repeat (5) @(negedge clk);
    check_eq("R9 retirement stalled", stat_count, 2);
    check_eq("R9 queue holds entries", cq_valid, 1);
    drain_en = 1;
    wait_drain();
    check_eq("R9 count after pops", stat_count, 0);

    // R10: outbound not ready
    req_ready = 0;
    @(negedge clk);
    sub_write = 1;
    #1;
    check_eq("R10 sub_wait", sub_wait, 1);
    repeat (3) @(negedge clk);
    check_eq("R10 no allocation", stat_count, 0);
    sub_write = 0;
    req_ready = 1;

    // R7: timeout edge
    cfg_timeout = 16'd5;
    submit(16'hD000);
    expect_c(2'd3, 10);
    repeat (5) @(negedge clk);
    check_eq("R7 still outstanding before limit", stat_count, 1);
    @(negedge clk);
    check_eq("R7 retired at limit", stat_count, 0);
    wait_drain();

    // R7 R8: silent oldest ahead of an answered entry
    submit(16'hD001);
    submit(16'hD002);
    expect_c(2'd3, 11);
    expect_c(2'd1, 12);
    respond(12, 0);
    wait_drain();
    check_eq("R7 count after timeout", stat_count, 0);
    check_eq("R6 drops unchanged", stat_drops, 2);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule